// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block stands between a memory controller's scheduler and the command bus of a four-bank double-data-rate SDRAM. Every cycle the scheduler may present one candidate command (open a row, read, write, close a row, refresh, or nothing) together with a bank number. The guard answers in the same cycle with one verdict. It can grant the command. It can stall the command, which the scheduler must then hold and offer again. It can flag the command as illegal because it conflicts with the bank's row state. The guard keeps its own copy of each bank's row state and of the minimum intervals that must pass after a row is opened or closed.

The guard also tells the data path when transfer data belongs on the bus. The read latency is the additive (posted) latency plus the CAS latency. The write latency is one cycle less than the read latency. Both are static configuration inputs. A granted read or write produces a one-cycle strobe exactly that many cycles later.

Top module: `ddr_bank_guard`

## Requirements
- R1: After reset every bank is idle, all timing intervals are expired, and no verdict or data strobe is raised. An open-row command to any bank is therefore granted in the first cycle after reset.
- R2: Command codes are 0 none, 1 open row, 2 read, 3 write, 4 close row, 5 refresh; codes 6 and 7 act as none. An open-row command to an idle bank is granted and marks the bank open. An open-row command to an open bank raises illegal.
- R3: A read or write to an idle bank raises illegal and is not granted.
- R4: A read or write to an open bank stalls until TRCD (3) cycles after that bank's open-row grant, and it is granted in exactly that cycle.
- R5: A close-row command stalls until TRAS (8) cycles after the bank's open-row grant. When granted it marks the bank idle. A close-row command to an idle bank is granted and leaves all timing unchanged.
- R6: An open-row command to an idle bank stalls until TRP (3) cycles after its close-row grant and TRC (11) cycles after its previous open-row grant, whichever is later.
- R7: A refresh is granted only when all banks are idle and every bank's TRP interval has expired; otherwise it stalls.
- R8: rd_lat_o equals AL+CL. rd_data_valid_o is high for exactly one cycle, rd_lat_o cycles after a granted read.
- R9: wr_lat_o equals AL+CL-1. wr_data_valid_o is high for exactly one cycle, wr_lat_o cycles after a granted write.
- R10: Banks are independent. Traffic and timers on one bank never delay an open-row command to another idle bank.
- R11: With cmd_valid_i low, or with a no-op code, no verdict is raised and no bank state changes.
- R12: For a valid non-no-op command exactly one of grant, stall and illegal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Candidate command present |
| cmd_op_i | input | 3 | Command code (see R2) |
| cmd_bank_i | input | 2 | Target bank |
| cfg_al_i | input | 3 | Additive latency, 0 to 4 |
| cfg_cl_i | input | 3 | CAS latency, 3 to 5 |
| grant_o | output | 1 | Command accepted this cycle |
| stall_o | output | 1 | Command must be held and retried |
| illegal_o | output | 1 | Command conflicts with row state |
| rd_lat_o | output | 4 | Read latency in cycles |
| wr_lat_o | output | 4 | Write latency in cycles |
| rd_data_valid_o | output | 1 | Read data expected on the bus |
| wr_data_valid_o | output | 1 | Write data expected on the bus |

## Verification
The read strobe and the write strobe can land in the same cycle. Because the write latency is one less than the read latency, a write granted one cycle after a read matures together with it. The bench grants a read and then a write on the same open bank in back-to-back cycles, for several latency settings. It then expects both strobes high in the one cycle RL after the read and both low in every other cycle of the window. That check shows the two shift paths neither merge nor hide each other.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } cmd_e;

    typedef enum logic [1:0] {
        VERDICT_NONE,
        VERDICT_GRANT,
        VERDICT_STALL,
        VERDICT_ILLEGAL
    } verdict_e;

endpackage

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
    parameter int TRCD = 3,
    parameter int TRP  = 3,
    parameter int TRAS = 8,
    parameter int TRC  = 11
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic act_go_i,
    input  logic pre_go_i,
    output logic open_o,
    output logic act_ok_o,
    output logic rw_ok_o,
    output logic pre_ok_o,
    output logic rp_done_o
);
    localparam int M1   = (TRCD > TRP) ? TRCD : TRP;
    localparam int M2   = (TRAS > TRC) ? TRAS : TRC;
    localparam int TMAX = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] rcd;
        logic [CW-1:0] ras;
        logic [CW-1:0] rc;
        logic [CW-1:0] rp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rcd = (st_q.rcd != '0) ? st_q.rcd - 1'b1 : '0;
        st_d.ras = (st_q.ras != '0) ? st_q.ras - 1'b1 : '0;
        st_d.rc  = (st_q.rc  != '0) ? st_q.rc  - 1'b1 : '0;
        st_d.rp  = (st_q.rp  != '0) ? st_q.rp  - 1'b1 : '0;
        if (act_go_i) begin
            st_d.open = 1'b1;
            st_d.rcd  = CW'(TRCD - 1);
            st_d.ras  = CW'(TRAS - 1);
            st_d.rc   = CW'(TRC - 1);
        end else if (pre_go_i) begin
            st_d.open = 1'b0;
            st_d.rp   = CW'(TRP - 1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign open_o    = st_q.open;
    assign act_ok_o  = !st_q.open && (st_q.rc == '0) && (st_q.rp == '0);
    assign rw_ok_o   = st_q.open && (st_q.rcd == '0);
    assign pre_ok_o  = st_q.open && (st_q.ras == '0);
    assign rp_done_o = (st_q.rp == '0);

    assert_act_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_go_i |-> (!st_q.open && st_q.rc == '0 && st_q.rp == '0));
    assert_open_after_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_go_i |=> st_q.open);
    assert_pre_after_ras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_go_i |-> (st_q.open && st_q.ras == '0));
    assert_idle_after_pre_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_go_i |=> !st_q.open);
endmodule

// File: rtl/ddr_lat_pipe.sv
module ddr_lat_pipe #(
    parameter int AL_W   = 3,
    parameter int CL_W   = 3,
    parameter int MAX_AL = 4,
    parameter int MAX_CL = 5,
    localparam int DEPTH = MAX_AL + MAX_CL,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_go_i,
    input  logic            wr_go_i,
    input  logic [AL_W-1:0] al_i,
    input  logic [CL_W-1:0] cl_i,
    output logic [LW-1:0]   rd_lat_o,
    output logic [LW-1:0]   wr_lat_o,
    output logic            rd_valid_o,
    output logic            wr_valid_o
);
    typedef struct packed {
        logic [DEPTH-1:0] rd;
        logic [DEPTH-1:0] wr;
    } pipe_st_t;

    pipe_st_t pipe_d, pipe_q;
    logic [LW-1:0] rl, wl;

    assign rl = LW'(al_i) + LW'(cl_i);
    assign wl = rl - 1'b1;

    always_comb begin
        pipe_d.rd = {pipe_q.rd[DEPTH-2:0], rd_go_i};
        pipe_d.wr = {pipe_q.wr[DEPTH-2:0], wr_go_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign rd_lat_o   = rl;
    assign wr_lat_o   = wl;
    assign rd_valid_o = pipe_q.rd[rl - 1'b1];
    assign wr_valid_o = pipe_q.wr[wl - 1'b1];

    assert_rd_strobe_origin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_go_i |=> pipe_q.rd[0]);
    assert_wr_strobe_origin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_go_i |=> pipe_q.wr[0]);
endmodule

// File: rtl/ddr_bank_guard.sv
module ddr_bank_guard #(
    parameter int NUM_BANKS = 4,
    parameter int TRCD      = 3,
    parameter int TRP       = 3,
    parameter int TRAS      = 8,
    parameter int TRC       = 11,
    parameter int AL_W      = 3,
    parameter int CL_W      = 3,
    parameter int MAX_AL    = 4,
    parameter int MAX_CL    = 5,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int LW       = $clog2(MAX_AL + MAX_CL + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  logic [2:0]        cmd_op_i,
    input  logic [BANK_W-1:0] cmd_bank_i,
    input  logic [AL_W-1:0]   cfg_al_i,
    input  logic [CL_W-1:0]   cfg_cl_i,
    output logic              grant_o,
    output logic              stall_o,
    output logic              illegal_o,
    output logic [LW-1:0]     rd_lat_o,
    output logic [LW-1:0]     wr_lat_o,
    output logic              rd_data_valid_o,
    output logic              wr_data_valid_o
);
    import ddr_guard_pkg::*;

    cmd_e     op;
    verdict_e verdict;
    logic [NUM_BANKS-1:0] bank_open, act_ok, rw_ok, pre_ok, rp_done;
    logic [NUM_BANKS-1:0] act_go, pre_go;
    logic all_idle, all_rp_done;

    assign op          = cmd_e'(cmd_op_i);
    assign all_idle    = ~|bank_open;
    assign all_rp_done = &rp_done;

    always_comb begin
        verdict = VERDICT_NONE;
        if (cmd_valid_i) begin
            case (op)
                CMD_ACT: verdict = bank_open[cmd_bank_i] ? VERDICT_ILLEGAL :
                                   act_ok[cmd_bank_i]    ? VERDICT_GRANT : VERDICT_STALL;
                CMD_RD,
                CMD_WR:  verdict = !bank_open[cmd_bank_i] ? VERDICT_ILLEGAL :
                                   rw_ok[cmd_bank_i]      ? VERDICT_GRANT : VERDICT_STALL;
                CMD_PRE: verdict = (!bank_open[cmd_bank_i] || pre_ok[cmd_bank_i]) ?
                                   VERDICT_GRANT : VERDICT_STALL;
                CMD_REF: verdict = (all_idle && all_rp_done) ? VERDICT_GRANT : VERDICT_STALL;
                default: verdict = VERDICT_NONE;
            endcase
        end
    end

    assign grant_o   = (verdict == VERDICT_GRANT);
    assign stall_o   = (verdict == VERDICT_STALL);
    assign illegal_o = (verdict == VERDICT_ILLEGAL);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_go[b] = grant_o && (op == CMD_ACT) && (cmd_bank_i == BANK_W'(b));
        assign pre_go[b] = grant_o && (op == CMD_PRE) && (cmd_bank_i == BANK_W'(b)) && bank_open[b];

        ddr_bank_timer #(
            .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRC(TRC)
        ) i_timer (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .act_go_i (act_go[b]),
            .pre_go_i (pre_go[b]),
            .open_o   (bank_open[b]),
            .act_ok_o (act_ok[b]),
            .rw_ok_o  (rw_ok[b]),
            .pre_ok_o (pre_ok[b]),
            .rp_done_o(rp_done[b])
        );
    end

    ddr_lat_pipe #(
        .AL_W(AL_W), .CL_W(CL_W), .MAX_AL(MAX_AL), .MAX_CL(MAX_CL)
    ) i_lat (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_go_i   (grant_o && op == CMD_RD),
        .wr_go_i   (grant_o && op == CMD_WR),
        .al_i      (cfg_al_i),
        .cl_i      (cfg_cl_i),
        .rd_lat_o  (rd_lat_o),
        .wr_lat_o  (wr_lat_o),
        .rd_valid_o(rd_data_valid_o),
        .wr_valid_o(wr_data_valid_o)
    );

    assert_one_verdict_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({grant_o, stall_o, illegal_o}));
    assert_quiet_nop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cmd_valid_i || op == CMD_NOP) |-> !(grant_o || stall_o || illegal_o));
    assert_ref_all_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o && op == CMD_REF) |-> (bank_open == '0));
    assert_rw_needs_open_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o && (op == CMD_RD || op == CMD_WR)) |-> bank_open[cmd_bank_i]);
    assert_nop_keeps_banks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_valid_i |=> $stable(bank_open));
endmodule

// File: tb/test_ddr_bank_guard.sv
module test_ddr_bank_guard;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [1:0] cmd_bank;
    logic [2:0] cfg_al, cfg_cl;
    logic       grant, stall, illegal, rd_dv, wr_dv;
    logic [3:0] rd_lat, wr_lat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ddr_bank_guard i_ddr_bank_guard (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_bank_i(cmd_bank), .cfg_al_i(cfg_al), .cfg_cl_i(cfg_cl),
        .grant_o(grant), .stall_o(stall), .illegal_o(illegal),
        .rd_lat_o(rd_lat), .wr_lat_o(wr_lat),
        .rd_data_valid_o(rd_dv), .wr_data_valid_o(wr_dv)
    );

    // {valid, op[2:0], bank[1:0], grant, stall, illegal}; op 1 ACT 2 RD 3 WR 4 PRE 5 REF
    localparam logic [8:0] VEC [21] = '{
        {1'b1, 3'd2, 2'd0, 3'b001},  // 0  R3 read idle bank
        {1'b1, 3'd1, 2'd0, 3'b100},  // 1  R1 open bank0
        {1'b1, 3'd2, 2'd0, 3'b010},  // 2  R4 read too early
        {1'b1, 3'd3, 2'd0, 3'b010},  // 3  R4 write too early
        {1'b1, 3'd1, 2'd1, 3'b100},  // 4  R10 open bank1
        {1'b1, 3'd1, 2'd0, 3'b001},  // 5  R2 open already open
        {1'b1, 3'd2, 2'd0, 3'b100},  // 6  R4 read allowed
        {1'b1, 3'd4, 2'd0, 3'b010},  // 7  R5 close too early
        {1'b1, 3'd4, 2'd0, 3'b010},  // 8  R5
        {1'b1, 3'd4, 2'd0, 3'b100},  // 9  R5 close at TRAS
        {1'b1, 3'd4, 2'd2, 3'b100},  // 10 R5 close idle bank
        {1'b1, 3'd1, 2'd0, 3'b010},  // 11 R6 reopen too early
        {1'b1, 3'd5, 2'd0, 3'b010},  // 12 R7 refresh with bank1 open
        {1'b1, 3'd4, 2'd1, 3'b100},  // 13 R5 close bank1
        {1'b1, 3'd5, 2'd0, 3'b010},  // 14 R7 refresh inside TRP
        {1'b1, 3'd5, 2'd0, 3'b010},  // 15 R7
        {1'b1, 3'd5, 2'd0, 3'b100},  // 16 R7 refresh granted
        {1'b1, 3'd0, 2'd0, 3'b000},  // 17 R11 no-op
        {1'b1, 3'd1, 2'd3, 3'b100},  // 18 R10 open bank3
        {1'b0, 3'd1, 2'd2, 3'b000},  // 19 R11 invalid open
        {1'b1, 3'd1, 2'd2, 3'b100}   // 20 R11 bank2 still idle
    };

    function automatic string row_tag(int i);
        case (i)
            0:             return "R3";
            1:             return "R1";
            2, 3, 6:       return "R4";
            4, 18:         return "R10";
            5:             return "R2";
            7, 8, 9, 10, 13: return "R5";
            11:            return "R6";
            12, 14, 15, 16: return "R7";
            default:       return "R11";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic v, logic [2:0] op, logic [1:0] bank);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_bank  = bank;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
        cmd_bank = 2'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic latency_run(int al, int cl);
        int rl, wl;
        rl = al + cl;
        wl = rl - 1;
        do_reset();
        cfg_al = 3'(al);
        cfg_cl = 3'(cl);
        step(1'b1, 3'd1, 2'd0);
        check("R1 open after reset", int'(grant), 1);
        repeat (3) step(1'b0, 3'd0, 2'd0);
        check("R8 rd_lat", int'(rd_lat), rl);
        check("R9 wr_lat", int'(wr_lat), wl);
        step(1'b1, 3'd2, 2'd0);
        check("R8 read grant", int'(grant), 1);
        for (int k = 1; k <= 11; k++) begin
            step(1'b0, 3'd0, 2'd0);
            check("R8 read strobe", int'(rd_dv), int'(k == rl));
        end
        step(1'b1, 3'd3, 2'd0);
        check("R9 write grant", int'(grant), 1);
        for (int k = 1; k <= 11; k++) begin
            step(1'b0, 3'd0, 2'd0);
            check("R9 write strobe", int'(wr_dv), int'(k == wl));
        end
        // read then write back to back: both strobes land together
        step(1'b1, 3'd2, 2'd0);
        check("R8 read grant pair", int'(grant), 1);
        step(1'b1, 3'd3, 2'd0);
        check("R9 write grant pair", int'(grant), 1);
        for (int k = 2; k <= 11; k++) begin
            step(1'b0, 3'd0, 2'd0);
            check("R8 paired read strobe", int'(rd_dv), int'(k == rl));
            check("R9 paired write strobe", int'(wr_dv), int'(k == rl));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
        cmd_bank = 2'd0;
        cfg_al = 3'd0;
        cfg_cl = 3'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 3'd0, 2'd0);
        check("R1 grant at reset", int'(grant), 0);
        check("R1 stall at reset", int'(stall), 0);
        check("R1 illegal at reset", int'(illegal), 0);
        check("R1 rd strobe at reset", int'(rd_dv), 0);
        check("R1 wr strobe at reset", int'(wr_dv), 0);

        for (int i = 0; i < 21; i++) begin
            step(VEC[i][8], VEC[i][7:5], VEC[i][4:3]);
            check({row_tag(i), " grant"},   int'(grant),   int'(VEC[i][2]));
            check({row_tag(i), " stall"},   int'(stall),   int'(VEC[i][1]));
            check({row_tag(i), " illegal"}, int'(illegal), int'(VEC[i][0]));
            if (VEC[i][8] && VEC[i][7:5] != 3'd0)
                check("R12 single verdict", int'(grant) + int'(stall) + int'(illegal), 1);
        end

        // R6: reopen after close waits TRP; bank2 opened at row 20
        for (int k = 1; k <= 7; k++) step(1'b0, 3'd0, 2'd0);
        step(1'b1, 3'd4, 2'd2);
        check("R5 close bank2 at TRAS", int'(grant), 1);
        step(1'b1, 3'd1, 2'd2);
        check("R6 reopen +1", int'(stall), 1);
        step(1'b1, 3'd1, 2'd2);
        check("R6 reopen +2", int'(stall), 1);
        step(1'b1, 3'd1, 2'd2);
        check("R6 reopen at TRC", int'(grant), 1);

        latency_run(0, 3);
        latency_run(2, 4);
        latency_run(4, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule